// File: doc/BRIEF.md
# Link Equalization Phase Sequencer

This block is the control state machine that walks a link through equalization at the 8 GT/s rate. After a start request it passes through Phase 1, then Phase 2, then an optional Phase 3, and it ends in the receiver-lock recovery state. The current phase appears in the two-bit equalization-control field of outgoing training sets. During Phase 2 and Phase 3 the receiving side judges link quality and asks for new transmitter coefficients until the error-rate target is met. Here the quality measurement is reduced to a pass/fail evaluation input, and the block raises a one-cycle request whenever a fresh coefficient set is needed.

Phase 3 tunes the transmitter in the reverse direction. It is always run in the endpoint role. In the root-port role a configuration input can skip it. Each evaluating phase allows a limited number of failed evaluations and each phase has a cycle timeout. When either limit is reached, the sequence ends in the recovery state with a failure flag set. The block also gates a one-time adaptive receiver equalization enable, and this enable depends on role, on phase and on any rate drop out of the 8 GT/s rate.

Top module: `eq_phase_seq`

## Requirements
- R1: A synchronous reset places the block in idle. In idle `ecField` = 2'b00, and `inRcvrLock`, `aeqEnable`, `coefReq` and `eqFail` are all 0.
- R2: `start` in idle makes `ecField` read 2'b01 (Phase 1) after the next edge. `start` has no effect while Phase 1, 2 or 3 is active.
- R3: In Phase 1, `ph1Done` moves the block to Phase 2, where `ecField` = 2'b10.
- R4: In Phase 2 or 3, a failing evaluation (`evalValid`=1, `evalPass`=0) that ends neither the iteration budget nor the timeout raises `coefReq` for exactly the cycle after that edge, and the phase is unchanged.
- R5: A passing evaluation in Phase 2 moves the block to Phase 3 (`ecField` = 2'b11) when Phase 3 is allowed, and to the recovery state otherwise.
- R6: Phase 3 is skipped only when `isRootPort`=1 and `ph3Disable`=1. In the endpoint role `ph3Disable` has no effect.
- R7: A passing evaluation in Phase 3 enters the recovery state. There `ecField` = 2'b00 and `inRcvrLock` = 1, and `eqFail` stays 0.
- R8: The MAX_ITER-th failing evaluation within one phase ends equalization in the recovery state with `eqFail`=1 and no `coefReq`. The iteration count restarts in every phase.
- R9: A phase that has lasted TIMEOUT cycles ends with `eqFail`=1 in the recovery state. A passing evaluation on that same edge takes priority over the timeout.
- R10: `aeqEnable` is 1 in Phase 2 in the endpoint role (`isRootPort`=0) and in Phase 3 in the root-port role. In all other cases it is 0.
- R11: `aeqEnable` is 0 in any cycle in which `rateDown` is 1.
- R12: The recovery state is held until `start`. `start` there restarts Phase 1 and clears `eqFail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an equalization sequence |
| isRootPort | input | 1 | 1 = root-port role, 0 = endpoint role |
| ph3Disable | input | 1 | Skip Phase 3 when in root-port role |
| ph1Done | input | 1 | Phase 1 exchange finished |
| evalValid | input | 1 | A quality evaluation result is present |
| evalPass | input | 1 | Error-rate target met (valid with evalValid) |
| rateDown | input | 1 | Rate is dropping to a lower generation |
| ecField | output | 2 | Equalization-control field for training sets |
| inRcvrLock | output | 1 | Sequencer is in the receiver-lock recovery state |
| aeqEnable | output | 1 | One-time adaptive receiver equalization enable |
| coefReq | output | 1 | One-cycle request for a new coefficient set |
| eqFail | output | 1 | Equalization ended without meeting the target |

## Verification
The main flow is run in three setups: endpoint with Phase 3 disabled, root port with Phase 3 allowed, and root port with Phase 3 disabled. Together these separate the role term from the configuration term in the Phase 3 decision and in the adaptive-equalization gate. Failing evaluations are applied back to back, spaced apart and up to the budget, which shows that coefficient requests are spaced correctly and that the iteration count restarts in each phase. Idle waits test the timeout in Phase 1 and Phase 2. Other cases cover a passing and a failing evaluation on the timeout edge, a rate drop during an enabled phase, and a reset in the middle of a phase.

// File: rtl/eq_seq_pkg.sv
package eq_seq_pkg;

  typedef enum logic [2:0] {
    EQ_IDLE = 3'd0,
    EQ_PH1  = 3'd1,
    EQ_PH2  = 3'd2,
    EQ_PH3  = 3'd3,
    EQ_LOCK = 3'd4
  } eqState_t;

  typedef struct packed {
    logic clrCnt;
    logic incIter;
    logic setFail;
    logic clrFail;
  } ctrlStrobe_t;

  localparam logic [1:0] EC_NONE = 2'b00;
  localparam logic [1:0] EC_PH1  = 2'b01;
  localparam logic [1:0] EC_PH2  = 2'b10;
  localparam logic [1:0] EC_PH3  = 2'b11;

endpackage

// File: rtl/eq_seq_dp.sv
module eq_seq_dp
  import eq_seq_pkg::*;
#(
  parameter int MAX_ITER = 8,
  parameter int TIMEOUT  = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t strb,
  output logic        iterLast,
  output logic        timeUp,
  output logic        coefReq,
  output logic        eqFail
);
  localparam int ITER_W = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1;
  localparam int TIME_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [ITER_W-1:0] ITER_END = ITER_W'(MAX_ITER - 1);
  localparam logic [TIME_W-1:0] TIME_END = TIME_W'(TIMEOUT - 1);

  logic [ITER_W-1:0] iterCnt;
  logic [TIME_W-1:0] cycleCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      iterCnt  <= '0;
      cycleCnt <= '0;
      coefReq  <= 1'b0;
      eqFail   <= 1'b0;
    end else begin
      coefReq <= strb.incIter;
      if (strb.clrCnt) begin
        iterCnt  <= '0;
        cycleCnt <= '0;
      end else begin
        cycleCnt <= cycleCnt + 1'b1;
        if (strb.incIter) iterCnt <= iterCnt + 1'b1;
      end
      if (strb.clrFail)      eqFail <= 1'b0;
      else if (strb.setFail) eqFail <= 1'b1;
    end
  end

  assign iterLast = (iterCnt == ITER_END);
  assign timeUp   = (cycleCnt == TIME_END);

  // R8: failed-evaluation count never reaches the budget
  p_iter_bound_r8: assert property (@(posedge clk) disable iff (rst)
    iterCnt <= ITER_END);

  // R9: phase timer never passes the timeout
  p_timer_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cycleCnt <= TIME_END);

endmodule

// File: rtl/eq_seq_ctrl.sv
module eq_seq_ctrl
  import eq_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        isRootPort,
  input  logic        ph3Disable,
  input  logic        ph1Done,
  input  logic        evalValid,
  input  logic        evalPass,
  input  logic        rateDown,
  input  logic        iterLast,
  input  logic        timeUp,
  output ctrlStrobe_t strb,
  output logic [1:0]  ecField,
  output logic        inRcvrLock,
  output logic        aeqEnable
);
  eqState_t state, nextState;
  logic ph3Allowed;
  logic evalGood;
  logic evalBad;

  assign ph3Allowed = !(isRootPort && ph3Disable);
  assign evalGood   = evalValid && evalPass;
  assign evalBad    = evalValid && !evalPass;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      EQ_IDLE, EQ_LOCK: begin
        if (start) begin
          nextState    = EQ_PH1;
          strb.clrFail = 1'b1;
        end
      end
      EQ_PH1: begin
        if (ph1Done) begin
          nextState = EQ_PH2;
        end else if (timeUp) begin
          nextState    = EQ_LOCK;
          strb.setFail = 1'b1;
        end
      end
      EQ_PH2, EQ_PH3: begin
        if (evalGood) begin
          nextState = (state == EQ_PH2 && ph3Allowed) ? EQ_PH3 : EQ_LOCK;
        end else if ((evalBad && iterLast) || timeUp) begin
          nextState    = EQ_LOCK;
          strb.setFail = 1'b1;
        end else if (evalBad) begin
          strb.incIter = 1'b1;
        end
      end
      default: nextState = EQ_IDLE;
    endcase
    strb.clrCnt = (nextState != state) || (state == EQ_IDLE) || (state == EQ_LOCK);
  end

  always_ff @(posedge clk) begin
    if (rst) state <= EQ_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    unique case (state)
      EQ_PH1:  ecField = EC_PH1;
      EQ_PH2:  ecField = EC_PH2;
      EQ_PH3:  ecField = EC_PH3;
      default: ecField = EC_NONE;
    endcase
  end

  assign inRcvrLock = (state == EQ_LOCK);
  assign aeqEnable  = !rateDown &&
                      (((state == EQ_PH2) && !isRootPort) ||
                       ((state == EQ_PH3) &&  isRootPort));

  // R2: start from idle reaches Phase 1 on the next edge
  p_start_ph1_r2: assert property (@(posedge clk) disable iff (rst)
    (state == EQ_IDLE && start) |=> (ecField == EC_PH1));

  // R12: recovery state held while start stays low
  p_lock_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (inRcvrLock && !start) |=> inRcvrLock);

  // R3: Phase 2 can only be entered from Phase 1
  p_ph2_entry_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ecField == EC_PH2) |-> $past(state == EQ_PH1));

endmodule

// File: rtl/eq_phase_seq.sv
module eq_phase_seq
  import eq_seq_pkg::*;
#(
  parameter int MAX_ITER = 8,
  parameter int TIMEOUT  = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       isRootPort,
  input  logic       ph3Disable,
  input  logic       ph1Done,
  input  logic       evalValid,
  input  logic       evalPass,
  input  logic       rateDown,
  output logic [1:0] ecField,
  output logic       inRcvrLock,
  output logic       aeqEnable,
  output logic       coefReq,
  output logic       eqFail
);
  ctrlStrobe_t strb;
  logic iterLast;
  logic timeUp;

  eq_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .isRootPort (isRootPort),
    .ph3Disable (ph3Disable),
    .ph1Done    (ph1Done),
    .evalValid  (evalValid),
    .evalPass   (evalPass),
    .rateDown   (rateDown),
    .iterLast   (iterLast),
    .timeUp     (timeUp),
    .strb       (strb),
    .ecField    (ecField),
    .inRcvrLock (inRcvrLock),
    .aeqEnable  (aeqEnable)
  );

  eq_seq_dp #(
    .MAX_ITER (MAX_ITER),
    .TIMEOUT  (TIMEOUT)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .iterLast (iterLast),
    .timeUp   (timeUp),
    .coefReq  (coefReq),
    .eqFail   (eqFail)
  );

  // R4: coefficient requests appear only inside an evaluating phase
  p_coef_in_phase_r4: assert property (@(posedge clk) disable iff (rst)
    coefReq |-> ecField[1]);

  // R8: a failure flag only rises together with entry to recovery
  p_fail_exit_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(eqFail) |-> inRcvrLock);

  // R10: adaptive equalization only during Phase 2 or Phase 3
  p_aeq_phase_r10: assert property (@(posedge clk) disable iff (rst)
    aeqEnable |-> ecField[1]);

  // R7: recovery state always sends a zero control field
  p_lock_ec_r7: assert property (@(posedge clk) disable iff (rst)
    inRcvrLock |-> (ecField == 2'b00));

endmodule

// File: tb/eq_phase_seq_tb.sv
module eq_phase_seq_tb;
  localparam int MAXI = 3;
  localparam int TMO  = 12;

  logic clk = 1'b0;
  logic rst, start, isRootPort, ph3Disable, ph1Done, evalValid, evalPass, rateDown;
  logic [1:0] ecField;
  logic inRcvrLock, aeqEnable, coefReq, eqFail;

  int checks = 0;
  int failures = 0;

  // reference model: 0 idle, 1..3 phases, 4 recovery
  int mPh = 0, mIter = 0, mCyc = 0;
  bit mFail = 0, mCoef = 0;

  always #10 clk = ~clk;

  eq_phase_seq #(.MAX_ITER(MAXI), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst(rst), .start(start), .isRootPort(isRootPort),
    .ph3Disable(ph3Disable), .ph1Done(ph1Done), .evalValid(evalValid),
    .evalPass(evalPass), .rateDown(rateDown), .ecField(ecField),
    .inRcvrLock(inRcvrLock), .aeqEnable(aeqEnable), .coefReq(coefReq),
    .eqFail(eqFail)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input bit r, input bit st, input bit p1,
                      input bit ev, input bit ps, input bit rd);
    int nPh, nIter, nCyc;
    bit nFail, nCoef;
    rst = r; start = st; ph1Done = p1; evalValid = ev; evalPass = ps; rateDown = rd;
    nPh = mPh; nIter = mIter; nFail = mFail; nCoef = 0;
    if (r) begin
      nPh = 0; nIter = 0; nCyc = 0; nFail = 0;
    end else begin
      if (mPh == 0 || mPh == 4) begin
        if (st) begin nPh = 1; nFail = 0; end
      end else if (mPh == 1) begin
        if (p1) nPh = 2;
        else if (mCyc == TMO - 1) begin nPh = 4; nFail = 1; end
      end else begin
        if (ev && ps) nPh = (mPh == 2 && !(isRootPort && ph3Disable)) ? 3 : 4;
        else if ((ev && mIter == MAXI - 1) || mCyc == TMO - 1) begin nPh = 4; nFail = 1; end
        else if (ev) begin nIter = mIter + 1; nCoef = 1; end
      end
      if (nPh != mPh || mPh == 0 || mPh == 4) begin nIter = 0; nCyc = 0; end
      else nCyc = mCyc + 1;
    end
    @(posedge clk);
    #5;
    mPh = nPh; mIter = nIter; mCyc = nCyc; mFail = nFail; mCoef = nCoef;
    chk(tag, "ecField", ecField, (mPh >= 1 && mPh <= 3) ? mPh : 0);
    chk(tag, "inRcvrLock", inRcvrLock, mPh == 4);
    chk(tag, "aeqEnable", aeqEnable,
        !rd && ((mPh == 2 && !isRootPort) || (mPh == 3 && isRootPort)));
    chk(tag, "coefReq", coefReq, mCoef);
    chk(tag, "eqFail", eqFail, mFail);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    isRootPort = 0; ph3Disable = 1;
    // R1 reset state
    step("R1", 1, 0, 0, 0, 0, 0);
    step("R1", 1, 1, 1, 1, 1, 0);
    idle("R1", 2);
    // endpoint flow, ph3Disable has no effect (R6)
    step("R2", 0, 1, 0, 0, 0, 0);
    step("R2", 0, 1, 0, 0, 0, 0);          // start ignored in Phase 1
    step("R3", 0, 0, 1, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 0, 0);
    step("R4", 0, 1, 0, 0, 0, 0);          // start ignored in Phase 2
    step("R11", 0, 0, 0, 0, 0, 1);
    step("R5", 0, 0, 0, 1, 1, 0);
    step("R6", 0, 0, 0, 1, 0, 0);
    step("R4", 0, 0, 0, 1, 0, 0);
    step("R7", 0, 0, 0, 1, 1, 0);
    idle("R12", 3);
    // root port with Phase 3 allowed
    isRootPort = 1; ph3Disable = 0;
    step("R12", 0, 1, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 0, 0, 0);
    step("R10", 0, 0, 0, 1, 0, 0);
    step("R5", 0, 0, 0, 1, 1, 0);
    step("R10", 0, 0, 0, 0, 0, 0);
    step("R11", 0, 0, 0, 0, 0, 1);
    step("R11", 0, 0, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 1, 1, 0);
    // root port with Phase 3 disabled
    ph3Disable = 1;
    step("R12", 0, 1, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 0, 0, 0);
    step("R6", 0, 0, 0, 1, 1, 0);
    idle("R6", 2);
    // iteration budget, back to back (R8)
    isRootPort = 0;
    step("R12", 0, 1, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < MAXI; i++) step("R8", 0, 0, 0, 1, 0, 0);
    idle("R8", 2);
    // budget restarts per phase
    ph3Disable = 0;
    step("R12", 0, 1, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 1, 1, 0);
    step("R8", 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 1, 1, 0);
    // Phase 1 timeout (R9)
    step("R12", 0, 1, 0, 0, 0, 0);
    idle("R9", TMO + 2);
    // Phase 2 timeout with failing evaluation on the edge
    step("R12", 0, 1, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 0, 0, 0);
    idle("R9", TMO - 1);
    step("R9", 0, 0, 0, 1, 0, 0);
    // Phase 3 pass on timeout edge wins
    step("R12", 0, 1, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 1, 0);
    idle("R9", TMO - 1);
    step("R9", 0, 0, 0, 1, 1, 0);
    idle("R9", 2);
    // reset mid-phase
    step("R12", 0, 1, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 0, 0, 0);
    step("R1", 1, 0, 0, 0, 0, 0);
    idle("R1", 2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule